// File: doc/BRIEF.md
# Clock Distribution Sync Release Controller

This block decides when the output clock dividers of a clock distribution tree may run. After reset it holds every divider in a static sync state. It keeps them there until the output PLL reports lock. It then releases all dividers on one clock edge, so that they start in phase with one another.

A configuration bit can release the dividers even while the PLL is unlocked. A second bit makes the block treat the PLL reference as valid even when the upstream indicator says it is not. A third bit powers down the lock detector. This also removes lock as a reason to release.

The lock input is asynchronous and passes through a multi-stage synchronizer. The upstream reference indicator can optionally be synchronized as well. If lock is lost while the force bit is clear, the block returns to the hold state. The next lock then gives a new aligned release.

Top module: `dist_sync_ctrl`

## Requirements
- R1: After reset, `sync_hold` is 1, every `rel_strobe` bit is 0, and `ref_valid` is 0 while both reference inputs are 0.
- R2: While held, if `lock_in` is first sampled high at rising edge k (and the lock detector is powered, force clear), all `rel_strobe` bits go high together after edge k+2 for exactly one cycle.
- R3: `sync_hold` stays 1 during the strobe cycle and falls after the next edge (k+3). It stays 0 while lock or force persists.
- R4: With `cfg_force_rel` = 1 sampled at edge k while held, the strobe appears after edge k regardless of lock, and `sync_hold` falls after edge k+1.
- R5: With `cfg_ld_pd` = 1, `ld_enable` is 0 and a high `lock_in` causes no release. Setting it while running returns the block to hold on that edge. `ld_enable` is 1 when `cfg_ld_pd` = 0.
- R6: If `lock_in` is sampled low at edge k while running and force is clear, `sync_hold` returns to 1 after edge k+2. A later lock produces a fresh one-cycle strobe.
- R7: While `cfg_force_rel` = 1, loss of lock leaves `sync_hold` at 0 with no strobe. Clearing force while unlocked returns to hold on that edge.
- R8: `ref_valid` is 1 whenever `cfg_ref_force` = 1 (same cycle). Otherwise it follows `ref_ok_in` delayed by two rising edges (synchronized variant, the default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_in | input | 1 | Asynchronous lock indication from the output PLL |
| ref_ok_in | input | 1 | Upstream reference-valid indication |
| cfg_ld_pd | input | 1 | 1 = lock detector powered down |
| cfg_force_rel | input | 1 | 1 = release dividers regardless of lock |
| cfg_ref_force | input | 1 | 1 = treat reference as valid |
| sync_hold | output | 1 | 1 = dividers held in static sync |
| rel_strobe | output | N_DIV | One-cycle release pulse, one bit per divider |
| ref_valid | output | 1 | Effective reference validity |
| ld_enable | output | 1 | Lock detector enable |

## Verification
The bench drops lock while running and then locks again. A controller that latched the release forever would keep `sync_hold` low and never issue a second strobe. It raises force while unlocked and later clears it. A design that routed force through the lock synchronizer would strobe two cycles late, and one that ignored the force drop would stay released. It powers down the lock detector while lock is high, both from hold and from run; a missing gate would let a strobe through. Checks land on the exact edge counts of the synchronizer, so an extra or missing stage shows up as a shifted strobe or a late `ref_valid`.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
   typedef enum logic [1:0] {
      ST_HOLD = 2'd0,
      ST_FIRE = 2'd1,
      ST_RUN  = 2'd2
   } rel_state_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   localparam int unsigned LAST = STAGES - 1;

   generate
      if (STAGES < dsc_pkg::MIN_SYNC_STAGES) begin : g_bad_stages
         $error("dsc_sync: STAGES below minimum");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[LAST];
endmodule

// File: rtl/dsc_ref_qual.sv
module dsc_ref_qual #(
   parameter bit          REF_SYNC    = 1'b1,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_ok_in,
   input  logic cfg_ref_force,
   input  logic cfg_ld_pd,
   input  logic lock_s,
   output logic ref_valid,
   output logic ld_enable,
   output logic lock_eff
);
   logic ref_s;

   generate
      if (REF_SYNC) begin : g_ref_sync
         dsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ref_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (ref_ok_in),
            .q     (ref_s)
         );
      end else begin : g_ref_direct
         assign ref_s = ref_ok_in;
      end
   endgenerate

   assign ld_enable = ~cfg_ld_pd;
   assign lock_eff  = lock_s & ld_enable;
   assign ref_valid = ref_s | cfg_ref_force;
endmodule

// File: rtl/dsc_release_fsm.sv
module dsc_release_fsm #(
   parameter int unsigned N_DIV = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock_eff,
   input  logic             force_rel,
   output logic             sync_hold,
   output logic [N_DIV-1:0] rel_strobe
);
   import dsc_pkg::*;

   generate
      if (N_DIV < 1) begin : g_bad_ndiv
         $error("dsc_release_fsm: N_DIV must be at least 1");
      end
   endgenerate

   rel_state_e state_q, state_d;
   logic       go;

   assign go = lock_eff | force_rel;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_HOLD: if (go)  state_d = ST_FIRE;
         ST_FIRE:          state_d = ST_RUN;
         ST_RUN:  if (!go) state_d = ST_HOLD;
         default:          state_d = ST_HOLD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_HOLD;
      else        state_q <= state_d;
   end

   assign sync_hold = (state_q != ST_RUN);

   genvar gi;
   generate
      for (gi = 0; gi < N_DIV; gi++) begin : g_strobe
         assign rel_strobe[gi] = (state_q == ST_FIRE);
      end
   endgenerate

   // R2
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rel_strobe[0] |=> !rel_strobe[0]);

   // R3
   hold_drop_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rel_strobe[0] |=> !sync_hold);

   // R3
   hold_fall_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sync_hold) |-> $past(rel_strobe[0]));

   // R7
   force_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_hold && force_rel) |=> !sync_hold);
endmodule

// File: rtl/dist_sync_ctrl.sv
module dist_sync_ctrl #(
   parameter int unsigned N_DIV       = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          REF_SYNC    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock_in,
   input  logic             ref_ok_in,
   input  logic             cfg_ld_pd,
   input  logic             cfg_force_rel,
   input  logic             cfg_ref_force,
   output logic             sync_hold,
   output logic [N_DIV-1:0] rel_strobe,
   output logic             ref_valid,
   output logic             ld_enable
);
   logic lock_s;
   logic lock_eff;

   dsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lock_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (lock_in),
      .q     (lock_s)
   );

   dsc_ref_qual #(.REF_SYNC(REF_SYNC), .SYNC_STAGES(SYNC_STAGES)) u_qual (
      .clk           (clk),
      .rst_n         (rst_n),
      .ref_ok_in     (ref_ok_in),
      .cfg_ref_force (cfg_ref_force),
      .cfg_ld_pd     (cfg_ld_pd),
      .lock_s        (lock_s),
      .ref_valid     (ref_valid),
      .ld_enable     (ld_enable),
      .lock_eff      (lock_eff)
   );

   dsc_release_fsm #(.N_DIV(N_DIV)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .lock_eff   (lock_eff),
      .force_rel  (cfg_force_rel),
      .sync_hold  (sync_hold),
      .rel_strobe (rel_strobe)
   );

   // R5
   pd_blocks_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_hold && !rel_strobe[0] && cfg_ld_pd && !cfg_force_rel) |=> !rel_strobe[0]);
endmodule

// File: tb/sim_dist_sync_ctrl.sv
module sim_dist_sync_ctrl;
   localparam int N = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lock_in = 1'b0, ref_ok_in = 1'b0, cfg_ld_pd = 1'b0;
   logic cfg_force_rel = 1'b0, cfg_ref_force = 1'b0;
   logic         sync_hold, ref_valid, ld_enable;
   logic [N-1:0] rel_strobe;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   logic [3:0] exp_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   dist_sync_ctrl #(.N_DIV(N)) u0 (
      .clk(clk), .rst_n(rst_n), .lock_in(lock_in), .ref_ok_in(ref_ok_in),
      .cfg_ld_pd(cfg_ld_pd), .cfg_force_rel(cfg_force_rel),
      .cfg_ref_force(cfg_ref_force), .sync_hold(sync_hold),
      .rel_strobe(rel_strobe), .ref_valid(ref_valid), .ld_enable(ld_enable)
   );

   // driver: apply inputs mid-cycle, push expected outputs after the next edge
   task automatic step(input logic lk, rf, pd, frc, rfrc,
                       input logic e_hold, e_str, e_ref, input string tag);
      @(negedge clk);
      #2;
      lock_in = lk; ref_ok_in = rf; cfg_ld_pd = pd;
      cfg_force_rel = frc; cfg_ref_force = rfrc;
      @(posedge clk);
      exp_q.push_back({e_hold, e_str, e_ref, ~pd});
      tag_q.push_back(tag);
   endtask

   // monitor: compare at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            logic [3:0] e, a;
            string t;
            logic split;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            split = !(rel_strobe == '0 || rel_strobe == '1);
            a = {sync_hold, (rel_strobe == '1), ref_valid, ld_enable};
            vectors++;
            if (a !== e || split) begin
               fails++;
               $display("FAIL %s: hold/strobe/ref/lden got %b (strobe bits %b) exp %b",
                        t, a, rel_strobe, e);
            end
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      step(0,0,0,0,0, 1,0,0, "R1");
      step(0,0,0,0,0, 1,0,0, "R1");
      // R2 lock release through synchronizer
      step(1,0,0,0,0, 1,0,0, "R2");
      step(1,0,0,0,0, 1,0,0, "R2");
      step(1,0,0,0,0, 1,1,0, "R2");
      step(1,0,0,0,0, 0,0,0, "R3");
      step(1,0,0,0,0, 0,0,0, "R3");
      step(1,0,0,0,0, 0,0,0, "R3");
      // R6 lock loss and relock
      step(0,0,0,0,0, 0,0,0, "R6");
      step(0,0,0,0,0, 0,0,0, "R6");
      step(0,0,0,0,0, 1,0,0, "R6");
      step(0,0,0,0,0, 1,0,0, "R6");
      step(1,0,0,0,0, 1,0,0, "R6");
      step(1,0,0,0,0, 1,0,0, "R6");
      step(1,0,0,0,0, 1,1,0, "R6");
      step(1,0,0,0,0, 0,0,0, "R6");
      // R7 force holds release through lock loss
      step(1,0,0,1,0, 0,0,0, "R7");
      for (int i = 0; i < 4; i++) step(0,0,0,1,0, 0,0,0, "R7");
      step(0,0,0,0,0, 1,0,0, "R7");
      // R4 force release while unlocked
      step(0,0,0,1,0, 1,1,0, "R4");
      step(0,0,0,1,0, 0,0,0, "R4");
      step(0,0,0,0,0, 1,0,0, "R4");
      // R5 lock detector power-down
      for (int i = 0; i < 5; i++) step(1,0,1,0,0, 1,0,0, "R5");
      step(1,0,0,0,0, 1,1,0, "R5");
      step(1,0,0,0,0, 0,0,0, "R5");
      step(1,0,1,0,0, 1,0,0, "R5");
      step(1,0,0,0,0, 1,1,0, "R5");
      step(1,0,0,0,0, 0,0,0, "R5");
      // R8 reference validity
      step(1,1,0,0,0, 0,0,0, "R8");
      step(1,1,0,0,0, 0,0,1, "R8");
      step(1,0,0,0,1, 0,0,1, "R8");
      step(1,0,0,0,1, 0,0,1, "R8");
      step(1,0,0,0,0, 0,0,0, "R8");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule